// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single down-counting timer channel of configurable width (16 bits by default). A separate register front end hands it a load strobe carrying a reload value, a 3-bit counting mode and a decimal-counting flag. The channel then produces a waveform bit and a live count, advancing only on cycles where the tick enable is high. A gate input can restart the count in the modes that use it.

Six counting behaviours are available: an interrupt-on-terminal level, a retriggerable one-shot, a rate generator, a square wave and two single-tick strobes. A reload value of zero stands for a full period of 2^CNT_W ticks. The decimal flag is only stored and reported back; counting is always binary. Out of reset the channel free-runs as a square wave with the full period. Throughout this brief, d is the number of ticks counted since the last load or restart, and N is the effective reload value.

Top module: `pit_channel`

## Requirements
- R1: After reset the reported mode is 3, the decimal flag is 0, the reload value is zero (period 2^CNT_W), wave_o is 1 and count_o is 0.
- R2: A reload value of 0 is used as N = 2^CNT_W. On the edge after such a load, count_o reads 0 in every mode.
- R3: A load strobe sets d to 0 on its edge and takes priority over a tick or gate edge in the same cycle. The outputs reflect the new setting from that edge on.
- R4: Mode 0: wave_o is 0 while d < N and 1 from d = N on, and stays 1.
- R5: Mode 1: wave_o is 1 while d < N and 0 from d = N on.
- R6: Mode 2: wave_o is 1 exactly when d is a nonzero multiple of N. count_o = (N - (d mod N)) mod 2^CNT_W.
- R7: Mode 3: wave_o is 1 when (d mod N) < (N+1)/2 (integer division). count_o = (N - ((2d) mod N)) mod 2^CNT_W, so it drops by two per tick.
- R8: Modes 4 and 5: wave_o is 1 only while d = N, which lasts one tick, and is 0 before and after.
- R9: A rising gate edge (gate_i 1 in this cycle, 0 in the last one) sets d to 0 in modes 1, 2, 3 and 5, even if a tick arrives in the same cycle. In modes 0 and 4 gate edges change nothing, and the gate level never pauses counting.
- R10: In modes 0, 1, 4 and 5, count_o = (N - d) mod 2^CNT_W and keeps wrapping past terminal.
- R11: Mode codes 6 and 7 act as, and are reported on mode_o as, modes 2 and 3. bcd_o returns the flag given at the last load and does not change the binary counting.
- R12: When tick_en is low and there is no load or restart, d and both outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer tick enable; counting advances once per high cycle |
| gate_i | input | 1 | Gate level; rising edges retrigger some modes |
| load_i | input | 1 | Load strobe for reload value, mode and flag |
| load_val_i | input | CNT_W | Reload value; 0 means 2^CNT_W |
| mode_i | input | 3 | Counting mode code, 0 to 7 |
| bcd_i | input | 1 | Decimal-counting flag, stored only |
| wave_o | output | 1 | Channel waveform bit |
| count_o | output | CNT_W | Live count, driven from registered state |
| mode_o | output | 3 | Effective mode after folding 6 and 7 |
| bcd_o | output | 1 | Stored decimal flag |

## Verification
Two functions can fall in the same cycle: a restart, caused either by a load strobe or by a gate rising edge in a retriggering mode, and a tick. The bench provokes this by raising tick_en in the very cycle of a load, and by raising the gate together with a tick in rate and one-shot modes. A gate edge in modes 0 and 4 together with a tick is provoked as well. The scoreboard model expects d to be 0 after the edge in the restart cases and expects normal advance in the ignored-edge cases, then compares wave_o and count_o on every following cycle.

// File: rtl/pit_pkg.sv
package pit_pkg;

   localparam logic [2:0] MD_TERM     = 3'd0;
   localparam logic [2:0] MD_ONESHOT  = 3'd1;
   localparam logic [2:0] MD_RATE     = 3'd2;
   localparam logic [2:0] MD_SQUARE   = 3'd3;
   localparam logic [2:0] MD_SWSTROBE = 3'd4;
   localparam logic [2:0] MD_HWSTROBE = 3'd5;

   // progress of a non-periodic count relative to its terminal value
   typedef enum logic [1:0] {
      PH_RUN  = 2'd0,
      PH_HIT  = 2'd1,
      PH_PAST = 2'd2
   } phase_e;

   // codes 6 and 7 behave as 2 and 3
   function automatic logic [2:0] fold_mode(input logic [2:0] m);
      return (m[2:1] == 2'b11) ? {1'b0, m[1:0]} : m;
   endfunction

   function automatic logic is_periodic(input logic [2:0] m);
      return (m == MD_RATE) || (m == MD_SQUARE);
   endfunction

   function automatic logic gate_retriggers(input logic [2:0] m);
      return (m == MD_ONESHOT) || (m == MD_RATE) ||
             (m == MD_SQUARE)  || (m == MD_HWSTROBE);
   endfunction

endpackage

// File: rtl/pit_gate_edge.sv
module pit_gate_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_i,
   output logic rise_o
);

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         logic prev_q;
         always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= gate_i;
         end
         assign rise_o = gate_i & ~prev_q;
      end else begin : g_sync
         logic [SYNC_STAGES:0] sh_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[SYNC_STAGES-1:0], gate_i};
         end
         assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
      end
   endgenerate

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o); // R9

endmodule

// File: rtl/pit_elapsed.sv
module pit_elapsed import pit_pkg::*; #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             restart_i,
   input  logic             periodic_i,
   input  logic [CNT_W:0]   period_i,
   output logic [CNT_W-1:0] elapsed_o,
   output logic             started_o,
   output phase_e           phase_o
);

   logic [CNT_W-1:0] e_q;
   logic             started_q;
   phase_e           phase_q;
   logic [CNT_W:0]   inc;
   logic             at_end;

   assign inc    = {1'b0, e_q} + 1'b1;
   assign at_end = (inc == period_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         e_q       <= '0;
         started_q <= 1'b0;
         phase_q   <= PH_RUN;
      end else if (restart_i) begin
         e_q       <= '0;
         started_q <= 1'b0;
         phase_q   <= PH_RUN;
      end else if (tick_i) begin
         started_q <= 1'b1;
         if (periodic_i && at_end) e_q <= '0;
         else                      e_q <= inc[CNT_W-1:0];
         case (phase_q)
            PH_RUN:  if (at_end) phase_q <= PH_HIT;
            PH_HIT:  phase_q <= PH_PAST;
            default: phase_q <= PH_PAST;
         endcase
      end
   end

   assign elapsed_o = e_q;
   assign started_o = started_q;
   assign phase_o   = phase_q;

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !restart_i) |=> ($stable(e_q) && $stable(phase_q))); // R12

   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (e_q == '0 && phase_q == PH_RUN && !started_q)); // R3

   AST_PHASE_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      periodic_i |-> ({1'b0, e_q} < period_i)); // R6

   AST_HIT_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_HIT && tick_i && !restart_i) |=> (phase_q == PH_PAST)); // R8

endmodule

// File: rtl/pit_wave.sv
module pit_wave import pit_pkg::*; #(
   parameter int CNT_W = 16
) (
   input  logic [2:0]       mode_i,
   input  logic [CNT_W:0]   period_i,
   input  logic [CNT_W-1:0] elapsed_i,
   input  logic             started_i,
   input  phase_e           phase_i,
   output logic             wave_o,
   output logic [CNT_W-1:0] count_o
);

   localparam int HW = CNT_W + 2;

   logic [CNT_W:0]   twice;
   logic [CNT_W-1:0] twice_mod;
   logic [HW-1:0]    half;
   logic [CNT_W-1:0] down_one;

   assign twice     = {elapsed_i, 1'b0};
   // a single subtraction suffices since elapsed_i < period_i here
   assign twice_mod = twice[CNT_W-1:0] - ((twice >= period_i) ? period_i[CNT_W-1:0] : '0);
   assign half      = ({1'b0, period_i} + 1'b1) >> 1;
   assign down_one  = period_i[CNT_W-1:0] - elapsed_i;

   always_comb begin
      wave_o  = 1'b0;
      count_o = down_one;
      case (mode_i)
         MD_TERM:    wave_o = (phase_i != PH_RUN);
         MD_ONESHOT: wave_o = (phase_i == PH_RUN);
         MD_RATE:    wave_o = started_i && (elapsed_i == '0);
         MD_SQUARE: begin
            wave_o  = ({2'b00, elapsed_i} < half);
            count_o = period_i[CNT_W-1:0] - twice_mod;
         end
         default:    wave_o = (phase_i == PH_HIT);
      endcase
   end

endmodule

// File: rtl/pit_channel.sv
module pit_channel import pit_pkg::*; #(
   parameter int CNT_W     = 16,
   parameter int GATE_SYNC = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             gate_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic [2:0]       mode_i,
   input  logic             bcd_i,
   output logic             wave_o,
   output logic [CNT_W-1:0] count_o,
   output logic [2:0]       mode_o,
   output logic             bcd_o
);

   localparam int             PER_W = CNT_W + 1;
   localparam logic [PER_W-1:0] FULL  = {1'b1, {CNT_W{1'b0}}};

   generate
      if (CNT_W < 2 || CNT_W > 30) begin : g_bad_width
         $error("pit_channel: CNT_W out of range");
      end
      if (GATE_SYNC < 0 || GATE_SYNC > 3) begin : g_bad_sync
         $error("pit_channel: GATE_SYNC out of range");
      end
   endgenerate

   logic [CNT_W-1:0] reload_q;
   logic [2:0]       mode_q;
   logic             bcd_q;
   logic [PER_W-1:0] period;
   logic             gate_rise;
   logic             restart;
   logic [CNT_W-1:0] elapsed;
   logic             started;
   phase_e           phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= '0;
         mode_q   <= MD_SQUARE;
         bcd_q    <= 1'b0;
      end else if (load_i) begin
         reload_q <= load_val_i;
         mode_q   <= fold_mode(mode_i);
         bcd_q    <= bcd_i;
      end
   end

   assign period  = (reload_q == '0) ? FULL : {1'b0, reload_q};
   assign restart = load_i | (gate_rise & gate_retriggers(mode_q));

   pit_gate_edge #(.SYNC_STAGES(GATE_SYNC)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .gate_i (gate_i),
      .rise_o (gate_rise)
   );

   pit_elapsed #(.CNT_W(CNT_W)) u_elapsed (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_en),
      .restart_i  (restart),
      .periodic_i (is_periodic(mode_q)),
      .period_i   (period),
      .elapsed_o  (elapsed),
      .started_o  (started),
      .phase_o    (phase)
   );

   pit_wave #(.CNT_W(CNT_W)) u_wave (
      .mode_i    (mode_q),
      .period_i  (period),
      .elapsed_i (elapsed),
      .started_i (started),
      .phase_i   (phase),
      .wave_o    (wave_o),
      .count_o   (count_o)
   );

   assign mode_o = mode_q;
   assign bcd_o  = bcd_q;

   AST_ZERO_IS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && load_val_i == '0) |=> (count_o == '0)); // R2

   AST_ALIAS_FOLDED: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && mode_i[2:1] == 2'b11) |=> (mode_o[2] == 1'b0)); // R11

   AST_ONESHOT_LOAD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && fold_mode(mode_i) == MD_ONESHOT) |=> wave_o); // R5

   AST_SQUARE_LOAD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && fold_mode(mode_i) == MD_SQUARE) |=> wave_o); // R7

endmodule

// File: tb/sim_pit_channel.sv
`timescale 1ns/1ps
module sim_pit_channel;

   localparam int FULLV = 65536;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        gate_i = 1'b0;
   logic        load_i = 1'b0;
   logic [15:0] load_val_i = '0;
   logic [2:0]  mode_i = '0;
   logic        bcd_i = 1'b0;
   logic        wave_o;
   logic [15:0] count_o;
   logic [2:0]  mode_o;
   logic        bcd_o;

   int checks = 0;
   int errors = 0;

   // reference model state
   int m_d = 0, m_n = FULLV, m_md = 3;
   bit m_bcd = 1'b0, m_gprev = 1'b0, g = 1'b0;

   // scoreboard queues
   bit    q_wave[$];
   int    q_cnt[$];
   int    q_md[$];
   bit    q_bcd[$];
   string q_tag[$];

   always #2 clk = ~clk;

   pit_channel u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate_i(gate_i),
      .load_i(load_i), .load_val_i(load_val_i), .mode_i(mode_i), .bcd_i(bcd_i),
      .wave_o(wave_o), .count_o(count_o), .mode_o(mode_o), .bcd_o(bcd_o)
   );

   function automatic bit exp_wave(int d, int n, int md);
      case (md)
         0: return d >= n;
         1: return d < n;
         2: return ((d % n) == 0) && (d != 0);
         3: return (d % n) < ((n + 1) / 2);
         default: return d == n;
      endcase
   endfunction

   function automatic int exp_cnt(int d, int n, int md);
      case (md)
         2: return (n - (d % n)) & 16'hFFFF;
         3: return (n - ((2 * (d % n)) % n)) & 16'hFFFF;
         default: return (n - d) & 16'hFFFF;
      endcase
   endfunction

   task automatic cyc(bit tk, bit ld, int val, int m, bit b, string tag);
      @(negedge clk);
      tick_en    = tk;
      gate_i     = g;
      load_i     = ld;
      load_val_i = val[15:0];
      mode_i     = m[2:0];
      bcd_i      = b;
      if (ld) begin
         m_n   = (val == 0) ? FULLV : val;
         m_md  = (m >= 6) ? m - 4 : m;
         m_bcd = b;
         m_d   = 0;
      end else if (g && !m_gprev &&
                   (m_md == 1 || m_md == 2 || m_md == 3 || m_md == 5)) begin
         m_d = 0;
      end else if (tk) begin
         m_d++;
      end
      m_gprev = g;
      q_wave.push_back(exp_wave(m_d, m_n, m_md));
      q_cnt.push_back(exp_cnt(m_d, m_n, m_md));
      q_md.push_back(m_md);
      q_bcd.push_back(m_bcd);
      q_tag.push_back(tag);
   endtask

   task automatic run(int n, string tag);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 0, 0, 1'b0, tag);
   endtask

   // monitor: compare after each edge
   always @(posedge clk) begin
      #1;
      if (q_wave.size() > 0) begin
         bit    ew;
         int    ec, em;
         bit    eb;
         string t;
         ew = q_wave.pop_front();
         ec = q_cnt.pop_front();
         em = q_md.pop_front();
         eb = q_bcd.pop_front();
         t  = q_tag.pop_front();
         checks++;
         if (wave_o !== ew || int'(count_o) != ec || int'(mode_o) != em || bcd_o !== eb) begin
            errors++;
            $display("FAIL %s: wave=%0b count=%0d mode=%0d bcd=%0b expected wave=%0b count=%0d mode=%0d bcd=%0b",
                     t, wave_o, count_o, mode_o, bcd_o, ew, ec, em, eb);
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      checks++;
      if (wave_o !== 1'b1 || count_o != 16'd0 || mode_o != 3'd3 || bcd_o !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset: wave=%0b count=%0d mode=%0d bcd=%0b expected wave=1 count=0 mode=3 bcd=0",
                  wave_o, count_o, mode_o, bcd_o);
      end

      // R1 R2 R7: reset setting, full 65536 period square wave
      for (int i = 0; i < 65540; i++)
         cyc(1'b1, 1'b0, 0, 0, 1'b0, (i < 4) ? "R1 reset square run" : "R2 full period wrap");

      // R4 R9 R10: mode 0, gate edges ignored, count wraps past terminal
      cyc(1'b0, 1'b1, 5, 0, 1'b0, "R4 load mode0");
      for (int i = 0; i < 10; i++) begin
         if (i == 2) g = 1'b1;
         if (i == 5) g = 1'b0;
         cyc(1'b1, 1'b0, 0, 0, 1'b0, (i < 5) ? "R4 R9 mode0 gate ignored" : "R10 mode0 wrap");
      end

      // R5 R9: mode 1 with retrigger
      cyc(1'b0, 1'b1, 4, 1, 1'b0, "R5 load mode1");
      run(6, "R5 mode1 run");
      g = 1'b1;
      cyc(1'b1, 1'b0, 0, 0, 1'b0, "R9 mode1 retrigger with tick");
      run(5, "R5 mode1 after retrigger");

      // R6 R12: mode 2 with idle cycles
      g = 1'b0;
      cyc(1'b0, 1'b1, 3, 2, 1'b0, "R6 load mode2");
      for (int i = 0; i < 12; i++)
         cyc((i % 3) != 2, 1'b0, 0, 0, 1'b0, "R6 R12 mode2 with idle cycles");
      g = 1'b1;
      cyc(1'b1, 1'b0, 0, 0, 1'b0, "R9 R3 mode2 gate edge beats tick");
      run(4, "R6 mode2 after restart");

      // R7: odd and even square periods
      g = 1'b0;
      cyc(1'b0, 1'b1, 5, 3, 1'b0, "R7 load mode3 odd");
      run(12, "R7 mode3 odd");
      cyc(1'b0, 1'b1, 6, 3, 1'b0, "R7 load mode3 even");
      run(8, "R7 mode3 even");
      g = 1'b1;
      cyc(1'b1, 1'b0, 0, 0, 1'b0, "R9 mode3 retrigger");
      run(3, "R7 mode3 after retrigger");

      // R8 R9: mode 4 strobe, gate edge ignored
      g = 1'b0;
      cyc(1'b0, 1'b1, 3, 4, 1'b0, "R8 load mode4");
      run(3, "R8 mode4 to terminal");
      g = 1'b1;
      cyc(1'b1, 1'b0, 0, 0, 1'b0, "R9 mode4 gate edge ignored");
      run(4, "R8 mode4 after strobe");

      // R8 R9: mode 5 strobe retriggered
      g = 1'b0;
      cyc(1'b0, 1'b1, 3, 5, 1'b0, "R8 load mode5");
      run(5, "R8 mode5 pulse");
      g = 1'b1;
      cyc(1'b1, 1'b0, 0, 0, 1'b0, "R9 mode5 retrigger");
      run(4, "R8 mode5 second pulse");

      // R11: aliases and decimal flag
      cyc(1'b0, 1'b1, 4, 6, 1'b1, "R11 load code6 flag set");
      run(6, "R11 code6 as rate");
      cyc(1'b0, 1'b1, 4, 7, 1'b0, "R11 load code7");
      run(6, "R11 code7 as square");

      // R3: load in the same cycle as a tick, and reload mid-count
      cyc(1'b1, 1'b1, 7, 0, 1'b1, "R3 load beats tick");
      run(3, "R3 mode0 after load");
      cyc(1'b1, 1'b1, 2, 0, 1'b0, "R3 reload mid count");
      run(3, "R3 mode0 short");

      // R2: zero reload in mode 4
      cyc(1'b0, 1'b1, 0, 4, 1'b0, "R2 load zero mode4");
      run(3, "R2 R10 zero reload countdown");

      // R10: mode 1 wraps past terminal
      cyc(1'b0, 1'b1, 2, 1, 1'b0, "R10 load mode1");
      run(5, "R10 mode1 wrap");

      cyc(1'b0, 1'b0, 0, 0, 1'b0, "R12 final idle");
      wait (q_wave.size() == 0);
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule